// File: doc/BRIEF.md
# Priority Interrupt Controller with Natural-Order Tiebreak

The block collects interrupt events from up to 54 sources and, each clock, picks one pending source to present to a processor. Each source carries a 3-bit level set by software. The level decides first. When several pending sources share the top level, the source with the smallest number wins. The winner's number, its vector (number plus a fixed offset of 8) and its level are held in registers. A request line rises when the winning level is strictly above the processor's present level.

Software programs the levels through a small word-wide register port. Each 16-bit word holds four 4-bit slots. Peripherals raise one-cycle set pulses, and enables gate each source. When the processor takes the request, it returns a one-cycle acknowledge, and that clears the pending flag of the source being presented. Only some source numbers are implemented. The rest have no pending flag and no level storage, so they can never win.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Word address a (0 to 13) holds sources 4a to 4a+3. Source 4a+k keeps its level in bits [4k+2:4k] of that word. Writes take effect at the clock edge where reg_we is high. Reads are combinational.
- R2: Bit 4k+3 of every word always reads 0, and writing to it has no effect. The level slots of unimplemented sources always read 0, and writes to them are ignored. Addresses 14 and 15 read 0.
- R3: After reset, every implemented source has level 4 and no flag is pending. irq_req, irq_num and irq_prio are 0.
- R4: Among pending, enabled sources, a higher level always wins, whatever the source numbers. Example: source 42 at level 7 beats source 0 at level 1.
- R5: When pending, enabled sources share the highest level, the lowest source number wins.
- R6: irq_vec always equals irq_num + 8. Source 0 maps to vector 8, and source 42 maps to vector 50.
- R7: A source whose level is 0, or whose src_en bit is low, never wins and never raises irq_req. Its pending flag is kept.
- R8: Only sources 0 to 16, 23, 24, 25, 27 and 42 are implemented. Set pulses on any other number are ignored, and such a number never appears with irq_req high.
- R9: irq_req is high only when a winner exists and its level is strictly greater than cpu_prio. The comparison uses cpu_prio as sampled one edge earlier.
- R10: When irq_ack is high while irq_req is high, the pending flag of the source on irq_num is cleared at that edge. A set pulse for the same source in the same cycle takes precedence, and the flag stays set.
- R11: A set pulse sampled at edge k makes the flag pending at edge k. The result appears on irq_req, irq_num and irq_prio at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_set | input | 54 | One-cycle event pulses, one bit per source |
| src_en | input | 54 | Per-source enable |
| cpu_prio | input | 3 | Current processor level |
| irq_ack | input | 1 | Acknowledge of the presented request |
| reg_addr | input | 4 | Level register word address |
| reg_we | input | 1 | Level register write enable |
| reg_wdata | input | 16 | Level register write data |
| reg_rdata | output | 16 | Level register read data |
| irq_req | output | 1 | Request to the processor |
| irq_num | output | 6 | Winning source number |
| irq_vec | output | 6 | Winning vector number |
| irq_prio | output | 3 | Winning level |

## Verification
The bench pits a high-numbered source at level 7 against source 0 at level 1. A controller that used natural order first would present source 0 there. Equal-level ties are checked, because a scan running the wrong way would pick the larger number. The strict comparison against cpu_prio is probed at equality, where a >= test would raise the request too early. Other targets are the ignored bit 3 of each slot, the unimplemented slots and events, level-0 and disabled sources, and an acknowledge that coincides with a new set pulse. Each of these exposes a design that loses or invents a pending event.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC = 54,
  parameter int PW = 3,
  parameter int VEC_BASE = 8,
  parameter int RST_LVL = 4,
  parameter int AW = 4,
  parameter logic [NSRC-1:0] IMPL_MASK = 54'h400_0B81_FFFF
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NSRC-1:0]                   src_set,
  input  logic [NSRC-1:0]                   src_en,
  input  logic [PW-1:0]                     cpu_prio,
  input  logic                              irq_ack,
  input  logic [AW-1:0]                     reg_addr,
  input  logic                              reg_we,
  input  logic [15:0]                       reg_wdata,
  output logic [15:0]                       reg_rdata,
  output logic                              irq_req,
  output logic [$clog2(NSRC)-1:0]           irq_num,
  output logic [$clog2(NSRC+VEC_BASE)-1:0]  irq_vec,
  output logic [PW-1:0]                     irq_prio
);
  localparam int IW = $clog2(NSRC);
  localparam int VW = $clog2(NSRC + VEC_BASE);

  logic [PW-1:0]   lvl_q [NSRC];
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] clr_vec;
  logic            best_v;
  logic [PW-1:0]   best_p;
  logic [IW-1:0]   best_n;
  logic [IW-1:0]   num_q;
  logic [PW-1:0]   prio_q;
  logic            req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++)
        lvl_q[i] <= IMPL_MASK[i] ? PW'(RST_LVL) : '0;
    end else if (reg_we) begin
      for (int i = 0; i < NSRC; i++)
        if (IMPL_MASK[i] && reg_addr == AW'(i / 4))
          lvl_q[i] <= reg_wdata[(i % 4) * 4 +: PW];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NSRC; i++)
      if (reg_addr == AW'(i / 4))
        reg_rdata[(i % 4) * 4 +: PW] = lvl_q[i];
  end

  assign clr_vec = (irq_ack && req_q) ? (NSRC'(1) << num_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_vec) | (src_set & IMPL_MASK);
  end

  always_comb begin
    best_v = 1'b0;
    best_p = '0;
    best_n = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend_q[i] && src_en[i] && lvl_q[i] != '0 && lvl_q[i] >= best_p) begin
        best_v = 1'b1;
        best_p = lvl_q[i];
        best_n = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q  <= '0;
      prio_q <= '0;
      req_q  <= 1'b0;
    end else begin
      num_q  <= best_n;
      prio_q <= best_p;
      req_q  <= best_v && (best_p > cpu_prio);
    end
  end

  assign irq_req  = req_q;
  assign irq_num  = num_q;
  assign irq_prio = prio_q;
  assign irq_vec  = VW'(num_q) + VW'(VEC_BASE);

  a_r9_req_above_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_prio > $past(cpu_prio)));

  a_r7_req_nonzero_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_prio != '0));

  a_r8_req_implemented: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> IMPL_MASK[irq_num]);

  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && !src_set[irq_num]) |=> !pend_q[$past(irq_num)]);

  a_r8_unimpl_never_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~IMPL_MASK) == '0);
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [53:0] src_set = '0;
  logic [53:0] src_en = '0;
  logic [2:0]  cpu_prio = '0;
  logic        irq_ack = 0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_req;
  logic [5:0]  irq_num;
  logic [5:0]  irq_vec;
  logic [2:0]  irq_prio;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_en(src_en),
    .cpu_prio(cpu_prio), .irq_ack(irq_ack), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_num(irq_num), .irq_vec(irq_vec), .irq_prio(irq_prio)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; src_set = '0; src_en = '1; cpu_prio = '0; irq_ack = 0; reg_we = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd_check(input string tag, input logic [3:0] a, input logic [15:0] exp);
    reg_addr = a;
    #1;
    check(tag, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic fire(input logic [53:0] m);
    src_set = m;
    @(negedge clk);
    src_set = '0;
    @(negedge clk);
  endtask

  task automatic ack_one();
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R3 req", 32'(irq_req), 0);
    check("R3 num", 32'(irq_num), 0);
    check("R3 prio", 32'(irq_prio), 0);
    rd_check("R3 word0", 4'd0, 16'h4444);
    rd_check("R3 word4 partial", 4'd4, 16'h0004);
    rd_check("R3 word13 reserved", 4'd13, 16'h0000);
    rd_check("R2 addr15", 4'd15, 16'h0000);
  endtask

  task automatic t_regs();
    do_reset();
    wr(4'd0, 16'hFFFF);
    rd_check("R2 bit3 ignored", 4'd0, 16'h7777);
    wr(4'd10, 16'hFFFF);
    rd_check("R2 reserved slots", 4'd10, 16'h0700);
    wr(4'd1, 16'h1234);
    rd_check("R1 field placement", 4'd1, 16'h1234);
    wr(4'd14, 16'hFFFF);
    rd_check("R2 addr14", 4'd14, 16'h0000);
  endtask

  task automatic t_level();
    do_reset();
    wr(4'd0, 16'h4441);
    wr(4'd10, 16'h0700);
    fire((54'd1 << 42) | 54'd1);
    check("R4 num", 32'(irq_num), 42);
    check("R6 vec 50", 32'(irq_vec), 50);
    check("R4 prio", 32'(irq_prio), 7);
    check("R4 req", 32'(irq_req), 1);
    ack_one();
    check("R10 next num", 32'(irq_num), 0);
    check("R6 vec 8", 32'(irq_vec), 8);
    check("R10 next prio", 32'(irq_prio), 1);
    ack_one();
    check("R10 drained", 32'(irq_req), 0);
  endtask

  task automatic t_tie();
    do_reset();
    wr(4'd0, 16'h5444);
    wr(4'd1, 16'h4454);
    src_set = (54'd1 << 5) | (54'd1 << 3);
    @(negedge clk);
    src_set = '0;
    check("R11 not yet", 32'(irq_req), 0);
    @(negedge clk);
    check("R11 latency", 32'(irq_req), 1);
    check("R5 tie low wins", 32'(irq_num), 3);
    ack_one();
    check("R5 then 5", 32'(irq_num), 5);
  endtask

  task automatic t_cpu();
    do_reset();
    wr(4'd0, 16'h4434);
    cpu_prio = 3'd3;
    fire(54'd1 << 1);
    check("R9 equal no req", 32'(irq_req), 0);
    check("R9 num shown", 32'(irq_num), 1);
    cpu_prio = 3'd2;
    @(negedge clk);
    check("R9 above req", 32'(irq_req), 1);
  endtask

  task automatic t_mask();
    do_reset();
    wr(4'd0, 16'h4044);
    fire(54'd1 << 2);
    check("R7 level0 no req", 32'(irq_req), 0);
    src_en[4] = 1'b0;
    fire(54'd1 << 4);
    check("R7 disabled no req", 32'(irq_req), 0);
    src_en[4] = 1'b1;
    @(negedge clk);
    check("R7 pending kept", 32'(irq_num), 4);
    check("R7 req after enable", 32'(irq_req), 1);
  endtask

  task automatic t_reserved();
    do_reset();
    fire((54'd1 << 17) | (54'd1 << 26) | (54'd1 << 53));
    check("R8 reserved no req", 32'(irq_req), 0);
    fire(54'd1 << 27);
    check("R8 impl 27 wins", 32'(irq_num), 27);
    check("R8 impl 27 req", 32'(irq_req), 1);
  endtask

  task automatic t_ack_set();
    do_reset();
    fire(54'd1 << 9);
    check("R10 setup", 32'(irq_num), 9);
    irq_ack = 1; src_set = 54'd1 << 9;
    @(negedge clk);
    irq_ack = 0; src_set = '0;
    @(negedge clk);
    check("R10 set beats ack", 32'(irq_req), 1);
    check("R10 still 9", 32'(irq_num), 9);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_regs();
        t_level();
        t_tie();
        t_cpu();
        t_mask();
        t_reserved();
        t_ack_set();
      end
      begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_run++;
        $display("FAIL watchdog: actual expired expected done");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule